// File: doc/BRIEF.md
# Synchronous Serial Shift Transceiver

This block moves 8-bit or 16-bit words over a clocked serial link, sending from a data-out pin and collecting from a data-in pin at the same time. Both directions run least significant bit first. Outgoing bits change on falling serial clock edges. Incoming bits are captured on rising edges into the same data registers, so once a transfer finishes those registers hold the word that came in.

The serial clock is either made inside the block, by dividing the system clock by one of eight powers of two and driving the result out, or taken from an external clock pin. An external clock is synchronized into the system clock domain. A small host register port selects the mode and clock, loads the data bytes, and starts a transfer. It also reports completion and overrun through flags that are cleared by writing zero. While the link is idle, the host can set the level of the data-out pin directly.

Top module: `sshift_xcvr`

## Requirements
- R1: Bits leave on `sdo` least significant first, each one changing on a falling serial clock edge. In 8-bit mode only the low data byte (address 1) is sent, and the high data byte (address 2) keeps its value.
- R2: `sdi` is sampled on every rising serial clock edge and shifted in from the top. After completion the data registers hold the received word, with the first bit received in bit 0.
- R3: When control bit 0 is 1 (16-bit mode), all 16 bits go out: the low byte first, then the high byte. The 16 bits received are split the same way.
- R4: In internal clock mode (control bit 1 = 0), control bits 4:2 = k give a serial clock period of 2^(k+1) system clocks. The serial clock idles high, and the first falling edge after a start sends bit 0.
- R5: `sclk_oe` is 1 only while an internal-clock transfer runs. After completion `sclk_out` stays high, with no edges, until the next start.
- R6: On the last rising edge, status bit 0 (busy) clears and status bit 1 (done) sets. `irq` mirrors the done bit.
- R7: After completion, `sdo` holds the last bit sent.
- R8: In external clock mode (control bit 1 = 1), falling `sclk_in` edges that arrive after a completed transfer set status bit 2 (overrun) and shift nothing. Edges seen before any transfer since the last control write set nothing.
- R9: The status register is at address 3. Writing 0 to bit 1 or bit 2 clears that flag, and writing 1 leaves it alone. Writing 1 to bit 0 starts a transfer when idle.
- R10: A status write while idle drives `sdo` to bit 3 of the written value. During a transfer, that level bit and writes to the data bytes are ignored.
- R11: A control write (address 0) aborts any transfer: busy clears, the serial clock returns high, and the bit count restarts.
- R12: After reset: `sdo` = 1, `sclk_out` = 1, `sclk_oe` = 0, `irq` = 0, and the status register reads 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Register address: 0 control, 1 data low, 2 data high, 3 status |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Internal serial clock, idles high |
| sclk_oe | output | 1 | Drive enable for `sclk_out` |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | Completion flag |

## Verification
The bench aims at the bit-order and byte-order boundaries. A reversed shift, or a 16-bit mode that sends the high byte first, garbles both the captured transmit word and the received word. An 8-bit transfer that writes into the high byte is caught because that byte is preloaded with a marker value. It measures the low phase of the internal clock at one rate and watches the clock pin after completion, which catches a wrong divider or a clock that keeps running. In external mode it sends one extra clock edge after completion: a design without overrun detection leaves the flag clear or corrupts the received data. An edge before any transfer must not raise the flag. Level writes and data writes during a transfer, and a control-write abort, check that a busy link is protected and can still be stopped.

// File: rtl/sshift_pkg.sv
package sshift_pkg;
  localparam int RATE_W = 3;
  localparam int CTRL_W = RATE_W + 2;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_LOW  = 2'd1;
  localparam logic [1:0] A_HIGH = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_LVL  = 3;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              ext;
    logic              wide;
  } ctrl_t;
endpackage

// File: rtl/sshift_clkgen.sv
module sshift_clkgen #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ext,
  input  logic [RATE_W-1:0] rate,
  input  logic              sclk_in,
  output logic              fall,
  output logic              rise,
  output logic              sclk_q
);
  localparam int NUM_RATES = 1 << RATE_W;
  localparam int PC_W      = (NUM_RATES > 1) ? NUM_RATES - 1 : 1;

  logic [PC_W-1:0] pcnt_q, pcnt_d;
  logic            sclk_d;
  logic [2:0]      xs_q, xs_d;
  logic [PC_W:0]   half;
  logic            tick, ext_fall, ext_rise;

  always_comb begin
    half     = (PC_W+1)'(1) << rate;
    tick     = run & ~ext & ({1'b0, pcnt_q} == half - (PC_W+1)'(1));
    xs_d     = {xs_q[1:0], sclk_in};
    ext_fall = xs_q[2] & ~xs_q[1];
    ext_rise = ~xs_q[2] & xs_q[1];
    if (!run || ext) begin
      pcnt_d = '0;
      sclk_d = 1'b1;
    end else if (tick) begin
      pcnt_d = '0;
      sclk_d = ~sclk_q;
    end else begin
      pcnt_d = pcnt_q + PC_W'(1);
      sclk_d = sclk_q;
    end
    fall = ext ? ext_fall : (tick & sclk_q);
    rise = ext ? ext_rise : (tick & ~sclk_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      sclk_q <= 1'b1;
      xs_q   <= 3'b111;
    end else begin
      pcnt_q <= pcnt_d;
      sclk_q <= sclk_d;
      xs_q   <= xs_d;
    end
  end

  // R4
  clk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> sclk_q);
endmodule

// File: rtl/sshift_shifter.sv
module sshift_shifter #(
  parameter int HALF_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                abort,
  input  logic                start,
  input  logic                wide,
  input  logic                ld_lo,
  input  logic                ld_hi,
  input  logic [HALF_W-1:0]   wbyte,
  input  logic                lvl_wr,
  input  logic                lvl_val,
  input  logic                fall,
  input  logic                rise,
  input  logic                sdi,
  output logic [2*HALF_W-1:0] word,
  output logic                busy,
  output logic                done_p,
  output logic                over_p,
  output logic                sdo
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int CNT_W  = $clog2(WORD_W);

  logic [WORD_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, last;
  logic              busy_q, busy_d, spent_q, spent_d, sdo_q, sdo_d;

  always_comb begin
    sr_d    = sr_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    spent_d = spent_q;
    sdo_d   = sdo_q;
    done_p  = 1'b0;
    over_p  = 1'b0;
    last    = wide ? CNT_W'(WORD_W - 1) : CNT_W'(HALF_W - 1);
    if (abort) begin
      busy_d  = 1'b0;
      cnt_d   = '0;
      spent_d = 1'b0;
    end else if (busy_q) begin
      if (fall) sdo_d = sr_q[0];
      if (rise) begin
        if (wide) sr_d = {sdi, sr_q[WORD_W-1:1]};
        else      sr_d[HALF_W-1:0] = {sdi, sr_q[HALF_W-1:1]};
        if (cnt_q == last) begin
          busy_d  = 1'b0;
          cnt_d   = '0;
          spent_d = 1'b1;
          done_p  = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end else begin
      if (ld_lo)  sr_d[HALF_W-1:0]      = wbyte;
      if (ld_hi)  sr_d[WORD_W-1:HALF_W] = wbyte;
      if (lvl_wr) sdo_d = lvl_val;
      if (fall && spent_q) over_p = 1'b1;
      if (start) begin
        busy_d  = 1'b1;
        cnt_d   = '0;
        spent_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      spent_q <= 1'b0;
      sdo_q   <= 1'b1;
    end else begin
      sr_q    <= sr_d;
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
      spent_q <= spent_d;
      sdo_q   <= sdo_d;
    end
  end

  assign word = sr_q;
  assign busy = busy_q;
  assign sdo  = sdo_q;

  // R1
  launch_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && fall && !abort) |=> (sdo_q == $past(sr_q[0])));
  // R8
  idle_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !ld_lo && !ld_hi) |=> $stable(sr_q));
  // R6
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= last));
  // R8
  overrun_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_p |-> !busy_q);
endmodule

// File: rtl/sshift_xcvr.sv
module sshift_xcvr
  import sshift_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_addr,
  input  logic              host_wr,
  input  logic [HALF_W-1:0] host_wdata,
  output logic [HALF_W-1:0] host_rdata,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sdi,
  output logic              sdo,
  output logic              irq
);
  localparam int WORD_W = 2 * HALF_W;

  ctrl_t             ctrl_q, ctrl_d;
  logic              done_q, done_d, ovr_q, ovr_d;
  logic              wr_ctrl, wr_lo, wr_hi, wr_stat;
  logic              fall, rise, sclk_q;
  logic [WORD_W-1:0] word;
  logic              busy, done_p, over_p;
  logic              unused_ok;

  assign wr_ctrl   = host_wr & (host_addr == A_CTRL);
  assign wr_lo     = host_wr & (host_addr == A_LOW);
  assign wr_hi     = host_wr & (host_addr == A_HIGH);
  assign wr_stat   = host_wr & (host_addr == A_STAT);
  assign unused_ok = ^host_wdata[HALF_W-1:CTRL_W];

  always_comb begin
    ctrl_d = wr_ctrl ? ctrl_t'(host_wdata[CTRL_W-1:0]) : ctrl_q;
    done_d = done_q;
    ovr_d  = ovr_q;
    if (wr_stat && !host_wdata[ST_DONE]) done_d = 1'b0;
    if (wr_stat && !host_wdata[ST_OVR])  ovr_d  = 1'b0;
    if (done_p) done_d = 1'b1;
    if (over_p) ovr_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      done_q <= done_d;
      ovr_q  <= ovr_d;
    end
  end

  sshift_clkgen #(.RATE_W(RATE_W)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .ext     (ctrl_q.ext),
    .rate    (ctrl_q.rate),
    .sclk_in (sclk_in),
    .fall    (fall),
    .rise    (rise),
    .sclk_q  (sclk_q)
  );

  sshift_shifter #(.HALF_W(HALF_W)) u_shf (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort   (wr_ctrl),
    .start   (wr_stat & host_wdata[ST_BUSY]),
    .wide    (ctrl_q.wide),
    .ld_lo   (wr_lo),
    .ld_hi   (wr_hi),
    .wbyte   (host_wdata),
    .lvl_wr  (wr_stat),
    .lvl_val (host_wdata[ST_LVL]),
    .fall    (fall),
    .rise    (rise),
    .sdi     (sdi),
    .word    (word),
    .busy    (busy),
    .done_p  (done_p),
    .over_p  (over_p),
    .sdo     (sdo)
  );

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_CTRL:  host_rdata[CTRL_W-1:0] = ctrl_q;
      A_LOW:   host_rdata = word[HALF_W-1:0];
      A_HIGH:  host_rdata = word[WORD_W-1:HALF_W];
      default: begin
        host_rdata[ST_BUSY] = busy;
        host_rdata[ST_DONE] = done_q;
        host_rdata[ST_OVR]  = ovr_q;
        host_rdata[ST_LVL]  = sdo;
      end
    endcase
  end

  assign sclk_out = sclk_q;
  assign sclk_oe  = busy & ~ctrl_q.ext;
  assign irq      = done_q;

  // R6
  irq_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_p |=> irq);
  // R5
  clk_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_oe |-> sclk_out);
  // R8
  ovr_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> !$past(busy));
endmodule

// File: tb/sim_sshift_xcvr.sv
module sim_sshift_xcvr;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       sclk_in = 1'b1;
  logic       sclk_out, sclk_oe;
  logic       sdi = 1'b0;
  logic       sdo, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  sshift_xcvr u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo), .irq(irq)
  );

  // {wide, ext, rate[2:0], tx[15:0], rx[15:0]}
  localparam logic [36:0] VEC [6] = '{
    {1'b0, 1'b0, 3'd0, 16'h00A5, 16'h003C},
    {1'b0, 1'b0, 3'd3, 16'h0081, 16'h00F0},
    {1'b1, 1'b0, 3'd1, 16'hBEEF, 16'h1234},
    {1'b1, 1'b0, 3'd7, 16'h8001, 16'hC35A},
    {1'b0, 1'b1, 3'd0, 16'h0096, 16'h0069},
    {1'b1, 1'b1, 3'd2, 16'h4D2B, 16'hA0F7}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic xfer(input logic wide, input logic ext, input logic [15:0] rx,
                      output logic [15:0] txcap, output logic oe_seen);
    int n;
    n = wide ? 16 : 8;
    txcap = '0;
    oe_seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (!ext) begin
        @(negedge sclk_out);
        #1 sdi = rx[i];
        if (i == 0) oe_seen = sclk_oe;
        @(posedge sclk_out);
        #1 txcap[i] = sdo;
      end else begin
        sclk_in = 1'b0; sdi = rx[i];
        repeat (8) @(negedge clk);
        txcap[i] = sdo;
        if (i == 0) oe_seen = sclk_oe;
        sclk_in = 1'b1;
        repeat (8) @(negedge clk);
      end
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    logic [7:0]  r;
    logic [15:0] cap;
    logic        oe;
    time         t0, t1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R12 reset state
    chk("R12 sdo", sdo, 1);
    chk("R12 sclk_out", sclk_out, 1);
    chk("R12 sclk_oe", sclk_oe, 0);
    chk("R12 irq", irq, 0);
    rd(2'd3, r); chk("R12 status", r, 8'h08);

    // R10 idle level
    wr(2'd3, 8'h00); #1 chk("R10 level low", sdo, 0);
    wr(2'd3, 8'h08); #1 chk("R10 level high", sdo, 1);

    // Vector table: R1 R2 R3 R5 R6 R7
    for (int v = 0; v < 6; v++) begin
      logic        wd, ex;
      logic [2:0]  rt;
      logic [15:0] tx, rx, m;
      {wd, ex, rt, tx, rx} = VEC[v];
      m = wd ? 16'hFFFF : 16'h00FF;
      wr(2'd0, {3'b000, rt, ex, wd});
      wr(2'd1, tx[7:0]);
      wr(2'd2, wd ? tx[15:8] : 8'h77);
      wr(2'd3, 8'h09);
      xfer(wd, ex, rx, cap, oe);
      chk(wd ? "R3 tx word" : "R1 tx word", cap & m, tx & m);
      chk("R5 oe during transfer", oe, !ex);
      rd(2'd1, r); chk("R2 rx low", r, rx[7:0]);
      rd(2'd2, r); chk(wd ? "R3 rx high" : "R1 high kept", r, wd ? rx[15:8] : 8'h77);
      rd(2'd3, r); chk("R6 status done not busy", r[1:0], 2'b10);
      chk("R6 irq", irq, 1);
      chk("R7 last bit held", sdo, wd ? tx[15] : tx[7]);
    end

    // R5 clock silent after completion
    wr(2'd0, 8'h00); wr(2'd1, 8'h5A); wr(2'd3, 8'h09);
    xfer(1'b0, 1'b0, 16'h0033, cap, oe);
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (sclk_out !== 1'b1 || sclk_oe !== 1'b0) bad++;
      end
      chk("R5 no clock after done", bad, 0);
    end

    // R9 write 1 keeps flag, write 0 clears
    wr(2'd3, 8'h0E); rd(2'd3, r); chk("R9 done kept on write 1", r[1], 1);
    wr(2'd3, 8'h08); rd(2'd3, r); chk("R9 done cleared on write 0", r[1], 0);
    chk("R9 irq cleared", irq, 0);

    // R4 rate 2: low phase of 4 system clocks
    wr(2'd0, 8'b000_010_0_0); wr(2'd3, 8'h09);
    @(negedge sclk_out); t0 = $time;
    @(posedge sclk_out); t1 = $time;
    chk("R4 half period", (t1 - t0) / PERIOD, 4);
    repeat (80) @(negedge clk);

    // R8 no overrun before any transfer
    wr(2'd0, 8'b000_000_1_0);
    sclk_in = 1'b0; repeat (8) @(negedge clk); sclk_in = 1'b1; repeat (8) @(negedge clk);
    rd(2'd3, r); chk("R8 no overrun before transfer", r[2], 0);

    // R8 overrun after completion
    wr(2'd1, 8'hC4); wr(2'd3, 8'h09);
    xfer(1'b0, 1'b1, 16'h00B1, cap, oe);
    sdi = 1'b0;
    sclk_in = 1'b0; repeat (8) @(negedge clk); sclk_in = 1'b1; repeat (8) @(negedge clk);
    rd(2'd3, r); chk("R8 overrun set", r[2], 1);
    rd(2'd1, r); chk("R8 data unchanged", r, 8'hB1);
    chk("R8 sdo unchanged", sdo, 1);
    wr(2'd3, 8'h08); rd(2'd3, r); chk("R9 overrun cleared", r[2], 0);

    // R10 writes ignored while busy, R11 abort
    wr(2'd1, 8'h00); wr(2'd3, 8'h09);
    wr(2'd3, 8'h00); #1 chk("R10 level ignored while busy", sdo, 1);
    wr(2'd1, 8'h55); rd(2'd1, r); chk("R10 data ignored while busy", r, 8'h00);
    rd(2'd3, r); chk("R11 busy before abort", r[0], 1);
    wr(2'd0, 8'b000_000_1_0);
    rd(2'd3, r); chk("R11 busy cleared by control write", r[0], 0);
    wr(2'd3, 8'h00); #1 chk("R11 level works after abort", sdo, 0);

    finished = 1;
    summary();
  end
endmodule